// File: doc/BRIEF.md
# Pager Codeword BCH Encoder and Checker

This block builds 32-bit paging codewords and checks received ones. In encode mode it takes a one-bit type flag (0 for an address word, 1 for a message word) and 20 information bits. It computes a 10-bit BCH(31,21) remainder over those 21 bits and adds an overall even-parity bit. The remainder is produced by a bit-serial polynomial divider that consumes one data bit per clock, most significant bit first.

In check mode the same divider runs over the first 31 bits of a received word. The block then reports whether the remainder is zero and whether the full 32-bit word has even parity. It does not correct errors.

A request is taken through a valid/ready handshake. Ready stays low for the whole of a job. The result is announced by a one-cycle valid pulse and stays on the outputs until the next job completes.

Top module: `pager_bch_codec`

## Requirements
- R1: While reset is held and on the first cycle after it is released, `req_ready` is 1, `out_valid` is 0, `out_word` is 0 and both flags are 0.
- R2: An encoded word has the type flag in bit 31 (bit 1 of the codeword, MSB) and the 20 information bits in bits 30..11, with information bit 19 in bit 30.
- R3: Encoded bits 10..1 hold the remainder of (type, info) multiplied by x^10 and divided by x^10+x^9+x^8+x^6+x^5+x^3+1. The coefficient of x^9 goes in bit 10.
- R4: Encoded bit 0 makes the XOR of all 32 bits equal to 0.
- R5: In encode mode (`req_op`=0), `out_valid` is high for exactly one cycle, 22 clock edges after the edge that accepted the request (21 shift cycles and one finish cycle).
- R6: In check mode (`req_op`=1), `out_valid` is high for exactly one cycle, 32 clock edges after the accepting edge (31 shift cycles and one finish cycle).
- R7: `req_ready` falls on the edge after an accepted request and stays low until the result is presented. Requests made while it is low are ignored and do not change the result.
- R8: In check mode, `out_syn_ok` is 1 exactly when bits 31..1 of the received word, read as a polynomial with bit 31 as the highest power, divide evenly by the generator. After an encode, `out_syn_ok` and `out_par_ok` are both 1.
- R9: In check mode, `out_par_ok` is 1 exactly when the XOR of all 32 received bits is 0, and `out_word` echoes the received word.
- R10: `out_word` and both flags keep their value in every cycle in which `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_op | input | 1 | 0 = encode, 1 = check |
| req_type | input | 1 | Type flag for encode (0 address, 1 message) |
| req_info | input | 20 | Information bits for encode |
| req_word | input | 32 | Received word for check |
| out_valid | output | 1 | One-cycle pulse: result ready |
| out_word | output | 32 | Encoded word, or the echoed received word |
| out_syn_ok | output | 1 | Remainder of bits 31..1 is zero |
| out_par_ok | output | 1 | Word has even parity |

## Verification
The hardest case to reach from the ports is a request offered while a job is in flight. For the handshake to be tested, that request must carry different data and the opposite operation, and must be present on the very cycle before the result appears. The bench drives such contending requests with fresh random contents on every busy cycle, holds them until ready returns, and then checks that the result still matches the original request. For check mode, the bench builds valid words with its own divider and then flips one bit, two bits, or only the parity bit. This covers the cases where syndrome and parity disagree, which random words seldom hit.

// File: rtl/pager_bch_pkg.sv
// Shared constants and types for the pager codeword encoder/checker.
// Assumes the fixed 32-bit layout: 1 type bit, 20 info bits,
// 10 check bits, 1 overall parity bit.
package pager_bch_pkg;
    localparam int          INFO_W  = 20;
    localparam int          CHK_W   = 10;
    localparam logic [9:0]  GEN_LOW = 10'h369; // x^9+x^8+x^6+x^5+x^3+1 (x^10 implied)
    localparam int          DATA_W  = INFO_W + 1;
    localparam int          BODY_W  = DATA_W + CHK_W;
    localparam int          CODE_W  = BODY_W + 1;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_SHIFT = 2'd1,
        SEQ_DONE  = 2'd2
    } seq_state_t;

    typedef enum logic {
        OP_ENCODE = 1'b0,
        OP_CHECK  = 1'b1
    } codec_op_t;
endpackage

// File: rtl/bch_lfsr.sv
// Bit-serial polynomial divider with a running parity accumulator.
// Encode mode computes the remainder of d(x)*x^CHK_W by feeding
// the input bit into the feedback. Check mode computes the plain
// remainder of the input polynomial by shifting the bit in at the
// bottom. Assumes the input arrives MSB first, one bit per step.
module bch_lfsr #(
    parameter int               CHK_W = 10,
    parameter logic [CHK_W-1:0] GEN   = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic             check_mode,
    input  logic             din,
    output logic [CHK_W-1:0] rem,
    output logic             par
);
    localparam int TOP = CHK_W - 1;

    logic [CHK_W-1:0] rem_next;
    logic             fb;

    // Next remainder for the selected division form.
    always_comb begin
        if (check_mode) begin
            fb       = rem[TOP];
            rem_next = {rem[TOP-1:0], din} ^ (fb ? GEN : '0);
        end else begin
            fb       = rem[TOP] ^ din;
            rem_next = {rem[TOP-1:0], 1'b0} ^ (fb ? GEN : '0);
        end
    end

    // Remainder and parity registers, cleared at job start.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            rem <= '0;
            par <= 1'b0;
        end else if (step) begin
            rem <= rem_next;
            par <= par ^ din;
        end
    end
endmodule

// File: rtl/bit_feeder.sv
// Parallel-in, serial-out shifter with a down counter of remaining bits.
// Presents the MSB of the loaded word first. Assumes load_len >= 1.
module bit_feeder #(
    parameter int W     = 31,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [W-1:0]     load_word,
    input  logic [CNT_W-1:0] load_len,
    input  logic             step,
    output logic             bit_out,
    output logic             last
);
    logic [W-1:0]     sreg;
    logic [CNT_W-1:0] remain;

    // Shift register and remaining-bit counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg   <= '0;
            remain <= '0;
        end else if (load) begin
            sreg   <= load_word;
            remain <= load_len;
        end else if (step) begin
            sreg   <= {sreg[W-2:0], 1'b0};
            remain <= remain - 1'b1;
        end
    end

    assign bit_out = sreg[W-1];
    assign last    = (remain == CNT_W'(1));
endmodule

// File: rtl/seq_ctrl.sv
// Job sequencer: idle -> shift (until the feeder reports its last bit)
// -> done (one finish cycle) -> idle. Ready only in idle.
module seq_ctrl
    import pager_bch_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic last,
    output logic ready,
    output logic step,
    output logic finish
);
    seq_state_t state, state_next;

    // Next-state decision.
    always_comb begin
        state_next = state;
        case (state)
            SEQ_IDLE:  if (start) state_next = SEQ_SHIFT;
            SEQ_SHIFT: if (last)  state_next = SEQ_DONE;
            SEQ_DONE:  state_next = SEQ_IDLE;
            default:   state_next = SEQ_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SEQ_IDLE;
        else        state <= state_next;
    end

    assign ready  = (state == SEQ_IDLE);
    assign step   = (state == SEQ_SHIFT);
    assign finish = (state == SEQ_DONE);
endmodule

// File: rtl/pager_bch_codec.sv
// Pager codeword encoder and checker (top level).
// Encode: {type, info} -> {type, info, BCH remainder, even parity}.
// Check: reports a zero remainder over bits 31..1 and even parity over
// all 32 bits. The divider runs serially, one bit per clock.
module pager_bch_codec
    import pager_bch_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_op,
    input  logic              req_type,
    input  logic [INFO_W-1:0] req_info,
    input  logic [CODE_W-1:0] req_word,
    output logic              out_valid,
    output logic [CODE_W-1:0] out_word,
    output logic              out_syn_ok,
    output logic              out_par_ok
);
    localparam int CNT_W = $clog2(BODY_W + 1);

    logic              start, step, finish, last, ser_bit;
    logic              par_acc;
    logic [CHK_W-1:0]  rem;
    logic [CODE_W-1:0] capt;
    logic [CODE_W-1:0] load_src;
    codec_op_t         op_q;

    assign start = req_valid && req_ready;

    // Word to be shifted: encode pads with zeros, check takes the raw word.
    always_comb begin
        if (req_op == OP_CHECK) load_src = req_word;
        else                    load_src = {req_type, req_info, {(CHK_W+1){1'b0}}};
    end

    // Capture the request for use when the job finishes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            capt <= '0;
            op_q <= OP_ENCODE;
        end else if (start) begin
            capt <= load_src;
            op_q <= codec_op_t'(req_op);
        end
    end

    seq_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .last   (last),
        .ready  (req_ready),
        .step   (step),
        .finish (finish)
    );

    bit_feeder #(.W(BODY_W), .CNT_W(CNT_W)) u_feed (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start),
        .load_word (load_src[CODE_W-1:1]),
        .load_len  ((req_op == OP_CHECK) ? CNT_W'(BODY_W) : CNT_W'(DATA_W)),
        .step      (step),
        .bit_out   (ser_bit),
        .last      (last)
    );

    bch_lfsr #(.CHK_W(CHK_W), .GEN(GEN_LOW)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (start),
        .step       (step),
        .check_mode (op_q == OP_CHECK),
        .din        (ser_bit),
        .rem        (rem),
        .par        (par_acc)
    );

    // Result registers, loaded only on the finish cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_word   <= '0;
            out_syn_ok <= 1'b0;
            out_par_ok <= 1'b0;
        end else begin
            out_valid <= finish;
            if (finish) begin
                if (op_q == OP_CHECK) begin
                    out_word   <= capt;
                    out_syn_ok <= (rem == '0);
                    out_par_ok <= ~(par_acc ^ capt[0]);
                end else begin
                    out_word   <= {capt[CODE_W-1:CHK_W+1], rem, par_acc ^ (^rem)};
                    out_syn_ok <= 1'b1;
                    out_par_ok <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pager_bch_codec_chk.sv
// Property checker for pager_bch_codec, attached by bind below.
// Observes the handshake, the result pulse and the result contents.
module pager_bch_codec_chk
    import pager_bch_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              out_valid,
    input logic [CODE_W-1:0] out_word,
    input logic              out_syn_ok,
    input logic              out_par_ok,
    input codec_op_t         op_q
);
    a_r4_even_parity: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && op_q == OP_ENCODE) |-> (^out_word) == 1'b0);

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    a_r8_encode_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && op_q == OP_ENCODE) |-> (out_syn_ok && out_par_ok));

    a_r9_check_parity: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && op_q == OP_CHECK) |-> (out_par_ok == ~(^out_word)));

    a_r10_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(out_word) && $stable(out_syn_ok) && $stable(out_par_ok)));
endmodule

bind pager_bch_codec pager_bch_codec_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .out_valid  (out_valid),
    .out_word   (out_word),
    .out_syn_ok (out_syn_ok),
    .out_par_ok (out_par_ok),
    .op_q       (op_q)
);

// File: tb/tb_pager_bch_codec.sv
module tb_pager_bch_codec;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_op = 1'b0;
    logic        req_type = 1'b0;
    logic [19:0] req_info = '0;
    logic [31:0] req_word = '0;
    logic        out_valid;
    logic [31:0] out_word;
    logic        out_syn_ok;
    logic        out_par_ok;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pager_bch_codec dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_type(req_type), .req_info(req_info), .req_word(req_word),
        .out_valid(out_valid), .out_word(out_word), .out_syn_ok(out_syn_ok),
        .out_par_ok(out_par_ok)
    );

    // Long division of a 31-bit polynomial by the generator.
    function automatic logic [9:0] ref_rem(input logic [30:0] w);
        logic [10:0] r = '0;
        for (int i = 30; i >= 0; i--) begin
            r = {r[9:0], w[i]};
            if (r[10]) r = r ^ 11'h769;
        end
        return r[9:0];
    endfunction

    function automatic logic [31:0] ref_encode(input logic t, input logic [19:0] info);
        logic [30:0] body;
        body = {t, info, 10'b0};
        body[9:0] = ref_rem(body);
        return {body, ^body};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic run_job(input logic op, input logic t, input logic [19:0] info,
                           input logic [31:0] rx, input bit noise);
        logic [31:0] exp_word;
        logic        exp_syn, exp_par;
        int          exp_lat, cnt;
        if (op == 1'b0) begin
            exp_word = ref_encode(t, info);
            exp_syn = 1'b1; exp_par = 1'b1; exp_lat = 22;
        end else begin
            exp_word = rx;
            exp_syn = (ref_rem(rx[31:1]) == 10'd0);
            exp_par = ((^rx) == 1'b0);
            exp_lat = 32;
        end
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_op = op; req_type = t; req_info = info; req_word = rx;
        @(negedge clk);
        cnt = 0;
        req_valid = 1'b0;
        while (!out_valid && cnt < 100) begin
            if (cnt == 5)
                check(req_ready == 1'b0, "R7 ready low while busy", {31'b0, req_ready}, 32'd0);
            if (noise) begin
                req_valid = !req_ready;
                req_op = ~op; req_type = ~t;
                req_info = 20'($urandom); req_word = $urandom;
            end
            @(negedge clk);
            cnt++;
        end
        req_valid = 1'b0;
        check(cnt == exp_lat, op ? "R6 check latency" : "R5 encode latency", cnt, exp_lat);
        if (op == 1'b0) begin
            check(out_word[31:11] == exp_word[31:11], "R2 type/info layout", out_word, exp_word);
            check(out_word[10:1] == exp_word[10:1], "R3 check bits", out_word, exp_word);
            check(out_word[0] == exp_word[0], "R4 parity bit", out_word, exp_word);
            check(out_syn_ok && out_par_ok, "R8 encode flags", {30'b0, out_syn_ok, out_par_ok}, 32'd3);
        end else begin
            check(out_syn_ok == exp_syn, "R8 syndrome flag", out_syn_ok, exp_syn);
            check(out_par_ok == exp_par && out_word == exp_word, "R9 parity flag/echo", out_word, exp_word);
        end
        if (noise)
            check(out_word == exp_word, "R7 busy request ignored", out_word, exp_word);
        @(negedge clk);
        check(out_valid == 1'b0, "R5 one-cycle pulse", out_valid, 0);
        repeat (2) @(negedge clk);
        check(out_word == exp_word && out_syn_ok == exp_syn && out_par_ok == exp_par,
              "R10 result held", out_word, exp_word);
    endtask

    initial begin
        logic [31:0] cw;
        int seed_sink;
        seed_sink = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        check(req_ready == 1'b1 && out_valid == 1'b0 && out_word == 32'd0 && !out_syn_ok && !out_par_ok,
              "R1 reset state", out_word, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1 && out_valid == 1'b0 && out_word == 32'd0,
              "R1 state after reset release", {30'b0, req_ready, out_valid}, 32'd2);

        // Directed encodes.
        run_job(1'b0, 1'b0, 20'h00000, 32'd0, 0);
        check(out_word == 32'd0, "R3 all-zero codeword", out_word, 32'd0);
        run_job(1'b0, 1'b1, 20'hFFFFF, 32'd0, 0);
        run_job(1'b0, 1'b0, 20'h00001, 32'd0, 0);
        run_job(1'b0, 1'b1, 20'h80000, 32'd0, 1);
        // Random encodes, some with contending requests.
        for (int i = 0; i < 12; i++)
            run_job(1'b0, 1'($urandom), 20'($urandom), 32'd0, (i % 3) == 0);

        // Check mode: valid words, single flips, parity-only flip, double flips.
        for (int i = 0; i < 6; i++) begin
            cw = ref_encode(1'($urandom), 20'($urandom));
            run_job(1'b1, 1'b0, 20'd0, cw, i == 2);
            run_job(1'b1, 1'b0, 20'd0, cw ^ (32'd2 << ($urandom % 31)), 0);
            run_job(1'b1, 1'b0, 20'd0, cw ^ 32'd1, 0);
            run_job(1'b1, 1'b0, 20'd0, cw ^ 32'h80000002, i == 4);
        end
        run_job(1'b1, 1'b0, 20'd0, 32'h00000000, 0);
        run_job(1'b1, 1'b0, 20'd0, 32'hFFFFFFFF, 0);
        for (int i = 0; i < 8; i++)
            run_job(1'b1, 1'b0, 20'd0, $urandom, i == 1);

        // Back-to-back: encode right after a check result.
        run_job(1'b0, 1'b1, 20'h5A5A5, 32'd0, 0);

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule